// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM Core

This block is a single-port synchronous memory whose word is made of byte lanes (two lanes of nine bits by default). Every command is taken on a clock edge together with its address. Write data and its lane enables follow two enabled edges later, and read data also appears two enabled edges later. A read and a write therefore pass through the pipeline at the same depth. Reads and writes can alternate on every clock, and no idle cycle is needed to turn the bus around.

A command either loads a new burst from the external address or advances the current burst. An advance steps through the remaining words of the aligned group of four, in linear or interleaved order. Writes can mask single lanes or abort all of them. A read with the output enable released becomes a dummy read. A clock-enable input freezes the whole pipeline for one cycle at a time. The bidirectional data bus is modelled as a data input, a data output and a drive-enable output.

Top module: `nbl_sram`

## Requirements
- R1: While reset is held and after it is released, `dq_oe` is low whatever the level of `oe_n`.
- R2: For a read issued on enabled edge E (`adv_ld`=0, `ce_n`=0, `we_n`=1), the word at that address is on `dq_out` after enabled edge E+2, and `dq_oe` is high while `oe_n` is low.
- R3: A write issued on edge E takes `din` and `bw_n` on enabled edge E+2. `bw_n[0]`=0 stores bits [8:0] (lane A) and `bw_n[1]`=0 stores bits [17:9] (lane B). Bits of a lane whose enable is high keep their old value.
- R4: A write with `bw_n`=2'b11 stores nothing, and a burst that continues after it still steps to the next address.
- R5: A cycle with `adv_ld`=0 and `ce_n`=1 deselects, and any advance cycles that follow stay deselected. Neither kind drives the bus, and neither kind changes memory.
- R6: An advance cycle (`adv_ld`=1) repeats the operation of the burst and uses the next burst address. The address keeps its upper bits, and its two low bits are base+k mod 4 when `lin_order`=1, or base XOR k when `lin_order`=0, where k is the number of advances so far (1 to 3, then it wraps).
- R7: A read issued on the cycle after a write to the same address returns the newly written value.
- R8: An edge with `cen_n`=1 is ignored. No command is taken, no write is stored, and `dq_out` and the drive state hold.
- R9: `oe_n` acts on `dq_oe` without waiting for a clock. A read with `oe_n` high leaves the bus undriven.
- R10: While a write occupies the output stage, `dq_oe` stays low even with `oe_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cen_n | input | 1 | Clock enable, active low; high stalls the edge |
| ce_n | input | 1 | Chip enable, active low |
| adv_ld | input | 1 | 0 = load new command, 1 = advance burst |
| we_n | input | 1 | 0 = write, 1 = read (on load) |
| lin_order | input | 1 | 1 = linear burst order, 0 = interleaved |
| addr | input | ADDR_W | External word address |
| bw_n | input | LANES | Lane write enables, active low, data phase |
| din | input | LANES*LANE_W | Write data, data phase |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_out | output | LANES*LANE_W | Read data |
| dq_oe | output | 1 | Bus drive enable |

## Verification
The bench builds the block with a five-bit address, which gives a 32-word array of eight burst groups. At that size every word can be filled first, and the random traffic then lands on the same words often. That brings read-after-write on adjacent cycles, lane masks overlaid on earlier data, and bursts that wrap inside a group within reach in a few thousand cycles. The lane width and lane count stay at their defaults, so the lane A and lane B bit positions are checked as specified.

// File: rtl/nbl_pkg.sv
package nbl_pkg;
  typedef enum logic [1:0] {OP_NONE = 2'd0, OP_RD = 2'd1, OP_WR = 2'd2} op_e;

  // low two bits of the k-th burst address from a group base
  function automatic logic [1:0] burst_step(input logic [1:0] base,
                                            input logic [1:0] k,
                                            input logic       lin);
    return lin ? (base + k) : (base ^ k);
  endfunction
endpackage

// File: rtl/nbl_burst_ctl.sv
module nbl_burst_ctl
  import nbl_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              ce_n,
  input  logic              adv_ld,
  input  logic              we_n,
  input  logic              lin_order,
  input  logic [ADDR_W-1:0] addr,
  output op_e               iss_op,
  output logic [ADDR_W-1:0] iss_addr
);
  op_e               bop;
  logic [ADDR_W-1:0] bbase;
  logic [1:0]        bcnt;
  logic [1:0]        nxt_cnt;

  assign nxt_cnt = bcnt + 2'd1;

  always_comb begin
    if (!adv_ld) begin
      iss_op   = ce_n ? OP_NONE : (we_n ? OP_RD : OP_WR);
      iss_addr = addr;
    end else begin
      iss_op   = bop;
      iss_addr = {bbase[ADDR_W-1:2], burst_step(bbase[1:0], nxt_cnt, lin_order)};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bop   <= OP_NONE;
      bbase <= '0;
      bcnt  <= '0;
    end else if (en) begin
      if (!adv_ld) begin
        bop   <= iss_op;
        bbase <= addr;
        bcnt  <= '0;
      end else if (bop != OP_NONE) begin
        bcnt  <= nxt_cnt;
      end
    end
  end
endmodule

// File: rtl/nbl_pipe.sv
module nbl_pipe
  import nbl_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  op_e               in_op,
  input  logic [ADDR_W-1:0] in_addr,
  output op_e               s2_op,
  output logic [ADDR_W-1:0] s2_addr
);
  op_e               s1_op;
  logic [ADDR_W-1:0] s1_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_op   <= OP_NONE;
      s1_addr <= '0;
      s2_op   <= OP_NONE;
      s2_addr <= '0;
    end else if (en) begin
      s1_op   <= in_op;
      s1_addr <= in_addr;
      s2_op   <= s1_op;
      s2_addr <= s1_addr;
    end
  end
endmodule

// File: rtl/nbl_array.sv
module nbl_array
  import nbl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  op_e                     s2_op,
  input  logic [ADDR_W-1:0]       s2_addr,
  input  logic [LANES-1:0]        bw_n,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] rd_q,
  output logic                    rd_vld,
  output logic                    wr_fire,
  output logic                    rd_fire
);
  localparam int W     = LANES * LANE_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic [W-1:0] mem [DEPTH];

  assign wr_fire = en && (s2_op == OP_WR);
  assign rd_fire = en && (s2_op == OP_RD);

  always_ff @(posedge clk) begin
    if (wr_fire) begin
      for (int l = 0; l < LANES; l++) begin
        if (!bw_n[l]) mem[s2_addr][l*LANE_W +: LANE_W] <= din[l*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= '0;
      rd_vld <= 1'b0;
    end else if (en) begin
      rd_vld <= (s2_op == OP_RD);
      if (s2_op == OP_RD) rd_q <= mem[s2_addr];
    end
  end
endmodule

// File: rtl/nbl_sram.sv
module nbl_sram
  import nbl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cen_n,
  input  logic                    ce_n,
  input  logic                    adv_ld,
  input  logic                    we_n,
  input  logic                    lin_order,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        bw_n,
  input  logic [LANES*LANE_W-1:0] din,
  input  logic                    oe_n,
  output logic [LANES*LANE_W-1:0] dq_out,
  output logic                    dq_oe
);
  localparam int W = LANES * LANE_W;

  logic              cyc_en;
  op_e               iss_op;
  logic [ADDR_W-1:0] iss_addr;
  op_e               s2_op;
  logic [ADDR_W-1:0] s2_addr;
  logic [W-1:0]      rd_q;
  logic              rd_vld;
  logic              wr_fire;
  logic              rd_fire;

  assign cyc_en = !cen_n;

  nbl_burst_ctl #(.ADDR_W(ADDR_W)) u_burst (
    .clk(clk), .rst_n(rst_n), .en(cyc_en), .ce_n(ce_n), .adv_ld(adv_ld),
    .we_n(we_n), .lin_order(lin_order), .addr(addr),
    .iss_op(iss_op), .iss_addr(iss_addr)
  );

  nbl_pipe #(.ADDR_W(ADDR_W)) u_pipe (
    .clk(clk), .rst_n(rst_n), .en(cyc_en), .in_op(iss_op), .in_addr(iss_addr),
    .s2_op(s2_op), .s2_addr(s2_addr)
  );

  nbl_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_array (
    .clk(clk), .rst_n(rst_n), .en(cyc_en), .s2_op(s2_op), .s2_addr(s2_addr),
    .bw_n(bw_n), .din(din), .rd_q(rd_q), .rd_vld(rd_vld),
    .wr_fire(wr_fire), .rd_fire(rd_fire)
  );

  assign dq_out = rd_q;
  assign dq_oe  = rd_vld && !oe_n;
endmodule

// File: rtl/nbl_sram_chk.sv
module nbl_sram_chk
  import nbl_pkg::*;
#(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cen_n,
  input logic         oe_n,
  input logic         dq_oe,
  input logic [W-1:0] dq_out,
  input op_e          s2_op,
  input logic         rd_vld,
  input logic         wr_fire,
  input logic         rd_fire
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) $rose(rst_n) |-> !dq_oe);

  // R9
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n) dq_oe |-> !oe_n);

  // R10
  wr_nodrive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> !rd_vld);

  // R2
  rd_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> rd_vld);

  // R5
  desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && s2_op == OP_NONE) |=> !rd_vld);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cen_n |=> ($stable(dq_out) && $stable(rd_vld)));
endmodule

bind nbl_sram nbl_sram_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .oe_n(oe_n), .dq_oe(dq_oe),
  .dq_out(dq_out), .s2_op(s2_op), .rd_vld(rd_vld), .wr_fire(wr_fire),
  .rd_fire(rd_fire)
);

// File: tb/tb_nbl_sram.sv
`timescale 1ns/1ps
module tb_nbl_sram;
  localparam int AW = 5;
  localparam int LW = 9;
  localparam int NL = 2;
  localparam int DW = LW * NL;
  localparam int DEPTH = 1 << AW;

  logic clk = 0;
  logic rst_n = 0;
  logic cen_n = 0, ce_n = 1, adv_ld = 0, we_n = 1, lin_order = 1, oe_n = 0;
  logic [AW-1:0] addr = '0;
  logic [NL-1:0] bw_n = '1;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dq_out;
  logic dq_oe;

  nbl_sram #(.ADDR_W(AW), .LANE_W(LW), .LANES(NL)) dut (
    .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .ce_n(ce_n), .adv_ld(adv_ld),
    .we_n(we_n), .lin_order(lin_order), .addr(addr), .bw_n(bw_n), .din(din),
    .oe_n(oe_n), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  always #10 clk = ~clk;

  int n_run = 0, n_fail = 0;
  bit finished = 0;
  string cur_req = "R2";

  // reference state
  logic [DW-1:0] ref_mem [DEPTH];
  int            p1_op = 0, p2_op = 0;            // 0 none, 1 read, 2 write
  logic [AW-1:0] p1_a = '0, p2_a = '0;
  logic [NL-1:0] p1_bw = '1, p2_bw = '1;
  logic [DW-1:0] p1_d = '0, p2_d = '0;
  int            b_op = 0;
  logic [AW-1:0] b_base = '0;
  int            b_k = 0;
  bit            m_rd = 0;
  logic [DW-1:0] m_dout = '0;

  function automatic logic [AW-1:0] next_addr(logic [AW-1:0] base, int k, logic lin);
    int lo;
    if (lin) lo = (int'(base[1:0]) + k) % 4;
    else     lo = int'(base[1:0]) ^ k;
    return (base & ~AW'(3)) | AW'(lo);
  endfunction

  function automatic logic [DW-1:0] pat(logic [AW-1:0] a, int salt);
    return DW'((int'(a) * 1237 + salt * 311 + 77) ^ 32'h2A5C5);
  endfunction

  task automatic chk(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_outs();
    bit exp_oe = m_rd && !oe_n;
    chk(dq_oe == exp_oe, cur_req, DW'(dq_oe), DW'(exp_oe));
    if (exp_oe) chk(dq_out == m_dout, cur_req, dq_out, m_dout);
  endtask

  // one cycle: drive, model the coming edge, check after it
  task automatic cyc(input logic c_ce, input logic c_adv, input logic c_we,
                     input logic [AW-1:0] c_a, input logic c_cen, input logic c_oe,
                     input logic c_lin, input logic [NL-1:0] c_bw, input logic [DW-1:0] c_d);
    int nop;
    logic [AW-1:0] na;
    ce_n = c_ce; adv_ld = c_adv; we_n = c_we; addr = c_a; cen_n = c_cen;
    oe_n = c_oe; lin_order = c_lin;
    if (p2_op == 2) begin din = p2_d; bw_n = p2_bw; end
    else begin din = DW'($urandom); bw_n = NL'($urandom); end
    if (!c_cen) begin
      if (p2_op == 2) begin
        for (int l = 0; l < NL; l++)
          if (!p2_bw[l]) ref_mem[p2_a][l*LW +: LW] = p2_d[l*LW +: LW];
        m_rd = 0;
      end else if (p2_op == 1) begin
        m_rd = 1; m_dout = ref_mem[p2_a];
      end else m_rd = 0;
      p2_op = p1_op; p2_a = p1_a; p2_bw = p1_bw; p2_d = p1_d;
      nop = 0; na = c_a;
      if (!c_adv) begin
        nop = c_ce ? 0 : (c_we ? 1 : 2);
        b_op = nop; b_base = c_a; b_k = 0;
      end else if (b_op != 0) begin
        b_k = (b_k + 1) % 4;
        na = next_addr(b_base, b_k, c_lin);
        nop = b_op;
      end
      p1_op = nop; p1_a = na; p1_bw = c_bw; p1_d = c_d;
    end
    @(posedge clk);
    @(negedge clk);
    check_outs();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(1, 0, 1, '0, 0, 0, 1, '1, '0);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 4; i++) @(negedge clk);
    // R1: held in reset with oe_n low
    chk(dq_oe == 1'b0, "R1", DW'(dq_oe), '0);
    rst_n = 1;
    @(negedge clk);
    chk(dq_oe == 1'b0, "R1", DW'(dq_oe), '0);

    // R3: fill every word through write bursts, full lane mask
    cur_req = "R3";
    for (int g = 0; g < DEPTH / 4; g++) begin
      cyc(0, 0, 0, AW'(g * 4), 0, 0, 1, 2'b00, pat(AW'(g * 4), 1));
      for (int k = 1; k < 4; k++)
        cyc(0, 1, 0, '0, 0, 0, 1, 2'b00, pat(AW'(g * 4 + k), 1));
    end
    idle(3);

    // R6: interleaved burst from 5, linear burst from 14
    cur_req = "R6";
    cyc(0, 0, 1, 5'd5, 0, 0, 0, '1, '0);
    for (int k = 1; k < 4; k++) cyc(0, 1, 1, '0, 0, 0, 0, '1, '0);
    cyc(0, 0, 1, 5'd14, 0, 0, 1, '1, '0);
    for (int k = 1; k < 4; k++) cyc(0, 1, 1, '0, 0, 0, 1, '1, '0);
    idle(3);

    // R3: single-lane writes, then R4: aborted write inside a burst
    cur_req = "R3";
    cyc(0, 0, 0, 5'd9, 0, 0, 1, 2'b10, 18'h3FFFF);   // lane A only
    cyc(0, 0, 0, 5'd10, 0, 0, 1, 2'b01, 18'h00000);  // lane B only
    idle(2);
    cyc(0, 0, 1, 5'd9, 0, 0, 1, '1, '0);
    cyc(0, 0, 1, 5'd10, 0, 0, 1, '1, '0);
    idle(3);
    cur_req = "R4";
    cyc(0, 0, 0, 5'd16, 0, 0, 1, 2'b11, 18'h12345);  // abort
    cyc(0, 1, 0, '0, 0, 0, 1, 2'b00, 18'h0BEEF);     // continues to 17
    idle(2);
    cyc(0, 0, 1, 5'd16, 0, 0, 1, '1, '0);
    cyc(0, 1, 1, '0, 0, 0, 1, '1, '0);
    idle(3);

    // R7: read right after write to the same word
    cur_req = "R7";
    cyc(0, 0, 0, 5'd3, 0, 0, 1, 2'b00, 18'h15A5A);
    cyc(0, 0, 1, 5'd3, 0, 0, 1, '1, '0);
    cyc(0, 0, 0, 5'd3, 0, 0, 1, 2'b01, 18'h2AAAA);
    cyc(0, 0, 1, 5'd3, 0, 0, 1, '1, '0);
    idle(3);

    // R8: stalls inside a read burst and inside a write data phase
    cur_req = "R8";
    cyc(0, 0, 1, 5'd20, 0, 0, 1, '1, '0);
    cyc(0, 1, 1, '0, 1, 0, 1, '1, '0);
    cyc(0, 1, 1, '0, 0, 0, 1, '1, '0);
    cyc(0, 1, 1, '0, 1, 0, 1, '1, '0);
    cyc(0, 1, 1, '0, 1, 0, 1, '1, '0);
    cyc(0, 0, 0, 5'd21, 0, 0, 1, 2'b00, 18'h1C3C3);
    cyc(1, 0, 1, '0, 0, 0, 1, '1, '0);
    cyc(1, 0, 1, '0, 1, 0, 1, '1, '0);
    cyc(1, 0, 1, '0, 1, 0, 1, '1, '0);
    idle(3);
    cyc(0, 0, 1, 5'd21, 0, 0, 1, '1, '0);
    idle(3);

    // R5: deselect then continue-deselect with write enable low
    cur_req = "R5";
    cyc(1, 0, 0, 5'd22, 0, 0, 1, 2'b00, 18'h00001);
    cyc(1, 1, 0, 5'd23, 0, 0, 1, 2'b00, 18'h00002);
    cyc(1, 1, 0, 5'd22, 0, 0, 1, 2'b00, 18'h00003);
    idle(3);
    cyc(0, 0, 1, 5'd22, 0, 0, 1, '1, '0);
    cyc(0, 0, 1, 5'd23, 0, 0, 1, '1, '0);
    idle(3);

    // R9: dummy read, then asynchronous output enable
    cur_req = "R9";
    cyc(0, 0, 1, 5'd12, 0, 1, 1, '1, '0);
    cyc(1, 0, 1, '0, 0, 1, 1, '1, '0);
    cyc(1, 0, 1, '0, 0, 1, 1, '1, '0);
    cyc(0, 0, 1, 5'd13, 0, 0, 1, '1, '0);
    cyc(1, 0, 1, '0, 0, 0, 1, '1, '0);
    cyc(1, 0, 1, '0, 0, 0, 1, '1, '0);   // read of 13 now in output reg
    oe_n = 1; #1;
    chk(dq_oe == 1'b0, "R9", DW'(dq_oe), '0);
    oe_n = 0; #1;
    chk(dq_oe == 1'b1, "R9", DW'(dq_oe), DW'(1));
    chk(dq_out == ref_mem[13], "R9", dq_out, ref_mem[13]);

    // R10: alternating write and read with oe_n low
    cur_req = "R10";
    for (int i = 0; i < 8; i++)
      cyc(0, 0, (i % 2 == 1), AW'(24 + i), 0, 0, 1, 2'b00, pat(AW'(i), 9));
    idle(3);

    // random traffic
    cur_req = "R7";
    for (int i = 0; i < 4000; i++) begin
      logic r_adv = $urandom % 2 == 0;
      logic r_lin = (r_adv) ? lin_order : logic'($urandom % 2);
      cyc(logic'($urandom % 8 == 0), r_adv, logic'($urandom % 2), AW'($urandom),
          logic'($urandom % 8 == 0), logic'($urandom % 6 == 0), r_lin,
          NL'($urandom), DW'($urandom));
    end
    idle(4);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule